// File: doc/BRIEF.md
# Rectangle Blit Engine with Logical Mix

The block moves a rectangle of pixels from a source map to a destination map. For every pixel it works out a source byte address and a destination byte address. It can read the source pixel and the destination pixel, merges them with a 4-bit logical mix code, and writes the result back to the destination. The source operand is either the pixel from the source map or a constant foreground colour held in a register. Each axis can be walked forwards or backwards. The first or the last pixel of the whole rectangle can be left undrawn, which suits chained span drawing.

Software programs six registers through a simple write port: control, size, pitches, source start, destination start and foreground colour. Setting the go bit of the control register starts the operation. `busy` stays high until the final write is accepted. Memory traffic goes one request at a time over a valid/ready port. Read data is returned in the same cycle that the read is accepted.

Top module: `blit_engine`

## Requirements
- R1: After synchronous reset `busy` and `mem_valid` are low and no request is issued until a start.
- R2: A write to register 0 with bit 0 set while idle raises `busy` on the next cycle. `busy` stays high until the last pixel's write is accepted, or until the last pixel is passed as suppressed, and then falls.
- R3: Register 1 holds width-1 in bits 11:0 and height-1 in bits 27:16, and bits 15:12 and 31:28 are ignored. The engine visits (width)x(height) pixels with X changing fastest.
- R4: Control bits 9:8 give the pixel size: 0, 1, 2 or 3 select 1, 2, 3 or 4 bytes, and `mem_size` carries that code. Along a row the address moves by the pixel size, and between rows it moves by the pitch. Register 2 holds the source pitch in bits 11:0 and the destination pitch in bits 27:16. Registers 3 and 4 hold the 22-bit source and destination start addresses, and all addresses wrap at 22 bits.
- R5: Control bit 1 set walks each row right-to-left, and control bit 2 set walks the rows bottom-up. The start address is always the first pixel visited.
- R6: Control bits 19:16 select the mix of S and D: 0:0, 1:S&D, 2:S&~D, 3:S, 4:~S&D, 5:D, 6:S^D, 7:S|D, 8:~S&~D, 9:S^~D, A:~D, B:S|~D, C:~S, D:~S|D, E:~S|~D, F:all ones.
- R7: Control bit 12 set takes S from the source map. When it is clear, S is the register 5 colour.
- R8: For each drawn pixel the engine issues, in this order: a source read (only if bit 12 is set and the mix depends on S), a destination read (only if the mix depends on D), and then the destination write.
- R9: A request that is not accepted keeps `mem_valid` high and holds its address, direction and data unchanged until `mem_ready`.
- R10: While `busy` is high, register writes and further starts have no effect.
- R11: Control bits 5:4 select the draw mode: 0 draws all pixels, 1 skips the first pixel visited, 2 skips the last pixel visited. A skipped pixel causes no memory request.
- R12: Write data bits above the pixel size are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | Operation in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 22 | Byte address of the pixel |
| mem_size | output | 2 | Pixel size code (bytes minus one) |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with an accepted read |

## Verification
The bench predicts every memory request and compares it with the design each time one is accepted. A design that moves to the next row with the wrong step, or ignores a direction bit, fails on the first pixel of the second row or the second pixel of a row. Random back-pressure catches a request whose address drifts while it is stalled. A reverse walk from address zero catches a design that wraps the address wrongly. A single-pixel rectangle with first or last suppression must produce no traffic, which catches skip logic that suppresses the wrong pixel. A sweep of all sixteen mix codes catches a missing or extra operand read and any swapped entry in the table. A go write issued during an operation catches a design that restarts or picks up new settings.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int ADDR_W = 22;
    localparam int PIX_W  = 32;
    localparam int CNT_W  = 12;
    localparam int REG_AW = 3;
    localparam int PIX_BYTES = PIX_W / 8;

    localparam logic [REG_AW-1:0] REG_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] REG_SIZE   = 3'd1;
    localparam logic [REG_AW-1:0] REG_PITCH  = 3'd2;
    localparam logic [REG_AW-1:0] REG_SSTART = 3'd3;
    localparam logic [REG_AW-1:0] REG_DSTART = 3'd4;
    localparam logic [REG_AW-1:0] REG_COLOUR = 3'd5;

    typedef enum logic [1:0] {
        DRAW_ALL   = 2'd0,
        SKIP_FIRST = 2'd1,
        SKIP_LAST  = 2'd2
    } draw_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PIX,
        ST_SRC,
        ST_DST,
        ST_WR
    } state_e;

    typedef struct packed {
        logic              x_rev;
        logic              y_rev;
        logic [1:0]        draw;
        logic [1:0]        depth;
        logic              s_from_map;
        logic [3:0]        mix;
        logic [CNT_W-1:0]  wm1;
        logic [CNT_W-1:0]  hm1;
        logic [CNT_W-1:0]  src_pitch;
        logic [CNT_W-1:0]  dst_pitch;
        logic [ADDR_W-1:0] src_start;
        logic [ADDR_W-1:0] dst_start;
        logic [PIX_W-1:0]  colour;
    } cfg_t;

    function automatic logic mix_needs_s(input logic [3:0] code);
        return !(code == 4'h0 || code == 4'h5 || code == 4'hA || code == 4'hF);
    endfunction

    function automatic logic mix_needs_d(input logic [3:0] code);
        return !(code == 4'h0 || code == 4'h3 || code == 4'hC || code == 4'hF);
    endfunction

    function automatic logic [PIX_W-1:0] mix_apply(input logic [3:0] code,
                                                   input logic [PIX_W-1:0] s,
                                                   input logic [PIX_W-1:0] d);
        logic [PIX_W-1:0] r;
        case (code)
            4'h0: r = '0;
            4'h1: r = s & d;
            4'h2: r = s & ~d;
            4'h3: r = s;
            4'h4: r = ~s & d;
            4'h5: r = d;
            4'h6: r = s ^ d;
            4'h7: r = s | d;
            4'h8: r = ~s & ~d;
            4'h9: r = s ^ ~d;
            4'hA: r = ~d;
            4'hB: r = s | ~d;
            4'hC: r = ~s;
            4'hD: r = ~s | d;
            4'hE: r = ~s | ~d;
            default: r = '1;
        endcase
        return r;
    endfunction

    function automatic logic [PIX_W-1:0] depth_mask(input logic [1:0] depth);
        logic [PIX_W-1:0] m;
        for (int i = 0; i < PIX_BYTES; i++) begin
            m[8*i +: 8] = (i <= int'(depth)) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs
    import blit_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = PIX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    output cfg_t          cfg,
    output logic          go
);

    localparam int HI_LSB = 16;

    logic accept;
    assign accept = we && !busy;
    assign go     = accept && (addr == REG_CTRL) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (accept) begin
            case (addr)
                REG_CTRL: begin
                    cfg.x_rev      <= wdata[1];
                    cfg.y_rev      <= wdata[2];
                    cfg.draw       <= wdata[5:4];
                    cfg.depth      <= wdata[9:8];
                    cfg.s_from_map <= wdata[12];
                    cfg.mix        <= wdata[19:16];
                end
                REG_SIZE: begin
                    cfg.wm1 <= wdata[CNT_W-1:0];
                    cfg.hm1 <= wdata[HI_LSB +: CNT_W];
                end
                REG_PITCH: begin
                    cfg.src_pitch <= wdata[CNT_W-1:0];
                    cfg.dst_pitch <= wdata[HI_LSB +: CNT_W];
                end
                REG_SSTART: cfg.src_start <= wdata[ADDR_W-1:0];
                REG_DSTART: cfg.dst_start <= wdata[ADDR_W-1:0];
                REG_COLOUR: cfg.colour    <= wdata;
                default: ;
            endcase
        end
    end

    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy && we |=> $stable(cfg));

endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          load,
    input  logic          step,
    input  cfg_t          cfg,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          first,
    output logic          last
);

    logic [CW-1:0] xcnt, ycnt;
    logic [AW-1:0] src_row, dst_row;
    logic [AW-1:0] src_row_n, dst_row_n, src_col_n, dst_col_n;
    logic [AW-1:0] pix_step;
    logic          row_end;

    assign pix_step = AW'(cfg.depth) + AW'(1);
    assign row_end  = (xcnt == cfg.wm1);

    assign src_row_n = cfg.y_rev ? src_row - AW'(cfg.src_pitch) : src_row + AW'(cfg.src_pitch);
    assign dst_row_n = cfg.y_rev ? dst_row - AW'(cfg.dst_pitch) : dst_row + AW'(cfg.dst_pitch);
    assign src_col_n = cfg.x_rev ? src_addr - pix_step : src_addr + pix_step;
    assign dst_col_n = cfg.x_rev ? dst_addr - pix_step : dst_addr + pix_step;

    assign first = (xcnt == '0) && (ycnt == '0);
    assign last  = row_end && (ycnt == cfg.hm1);

    always_ff @(posedge clk) begin
        if (rst) begin
            xcnt     <= '0;
            ycnt     <= '0;
            src_row  <= '0;
            dst_row  <= '0;
            src_addr <= '0;
            dst_addr <= '0;
        end else if (load) begin
            xcnt     <= '0;
            ycnt     <= '0;
            src_row  <= cfg.src_start;
            dst_row  <= cfg.dst_start;
            src_addr <= cfg.src_start;
            dst_addr <= cfg.dst_start;
        end else if (step) begin
            if (row_end) begin
                xcnt     <= '0;
                ycnt     <= ycnt + CW'(1);
                src_row  <= src_row_n;
                dst_row  <= dst_row_n;
                src_addr <= src_row_n;
                dst_addr <= dst_row_n;
            end else begin
                xcnt     <= xcnt + CW'(1);
                src_addr <= src_col_n;
                dst_addr <= dst_col_n;
            end
        end
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> (xcnt <= cfg.wm1) && (ycnt <= cfg.hm1));

    a_r3_no_step_past_end: assert property (@(posedge clk) disable iff (rst)
        step |-> !last);

endmodule

// File: rtl/blit_mix.sv
module blit_mix
    import blit_pkg::*;
#(
    parameter int DW = PIX_W
) (
    input  logic [3:0]    code,
    input  logic [1:0]    depth,
    input  logic [DW-1:0] s_op,
    input  logic [DW-1:0] d_op,
    output logic [DW-1:0] result
);

    assign result = mix_apply(code, s_op, d_op) & depth_mask(depth);

endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [PIX_W-1:0]  cfg_wdata,
    output logic              busy,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic              mem_ready,
    input  logic [PIX_W-1:0]  mem_rdata
);

    cfg_t   cfg;
    logic   go;
    state_e state_q, state_d;
    logic   step, first, last, skip, need_s, need_d;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [PIX_W-1:0]  s_val, d_val, s_op, mix_out;

    assign busy = (state_q != ST_IDLE);

    blit_regs #(.AW(REG_AW), .DW(PIX_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .busy(busy), .cfg(cfg), .go(go)
    );

    blit_walker #(.AW(ADDR_W), .CW(CNT_W)) u_walk (
        .clk(clk), .rst(rst), .active(busy), .load(go), .step(step), .cfg(cfg),
        .src_addr(src_addr), .dst_addr(dst_addr), .first(first), .last(last)
    );

    assign s_op = cfg.s_from_map ? s_val : cfg.colour;

    blit_mix #(.DW(PIX_W)) u_mix (
        .code(cfg.mix), .depth(cfg.depth), .s_op(s_op), .d_op(d_val), .result(mix_out)
    );

    assign need_s = cfg.s_from_map && mix_needs_s(cfg.mix);
    assign need_d = mix_needs_d(cfg.mix);
    assign skip   = (cfg.draw == SKIP_FIRST && first) || (cfg.draw == SKIP_LAST && last);

    always_comb begin
        state_d   = state_q;
        step      = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dst_addr;
        mem_wdata = '0;
        mem_size  = cfg.depth;
        case (state_q)
            ST_IDLE: if (go) state_d = ST_PIX;
            ST_PIX: begin
                if (skip) begin
                    if (last) state_d = ST_IDLE;
                    else      step    = 1'b1;
                end else if (need_s) state_d = ST_SRC;
                else if (need_d)     state_d = ST_DST;
                else                 state_d = ST_WR;
            end
            ST_SRC: begin
                mem_valid = 1'b1;
                mem_addr  = src_addr;
                if (mem_ready) state_d = need_d ? ST_DST : ST_WR;
            end
            ST_DST: begin
                mem_valid = 1'b1;
                if (mem_ready) state_d = ST_WR;
            end
            ST_WR: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = mix_out;
                if (mem_ready) begin
                    if (last) state_d = ST_IDLE;
                    else begin
                        step    = 1'b1;
                        state_d = ST_PIX;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            s_val   <= '0;
            d_val   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SRC && mem_ready) s_val <= mem_rdata;
            if (state_q == ST_DST && mem_ready) d_val <= mem_rdata;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_valid);

    a_r9_hold_request: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                    && $stable(mem_wdata));

    a_r12_upper_zero: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_we |-> (mem_wdata & ~depth_mask(mem_size)) == '0);

    a_r2_done_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(state_q) == ST_WR) || ($past(state_q) == ST_PIX));

endmodule

// File: tb/test_blit_engine.sv
module test_blit_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        busy, mem_valid, mem_we;
    logic [21:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    blit_engine i_blit_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .busy(busy), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit stall = 0;

    logic [7:0] mem  [int];
    logic [7:0] refm [int];

    typedef struct {
        bit          we;
        int          addr;
        int          nb;
        logic [31:0] data;
    } txn_t;
    txn_t exp_q[$];

    // operation settings
    int w, h, dep, sp, dp, ss, ds, drw;
    bit xn, yn, fs;
    logic [3:0]  mx;
    logic [31:0] fg;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] seed_b(int a);
        return 8'(a * 37 + (a >>> 5) + 11);
    endfunction

    function automatic logic [31:0] mem_px(int a, int nb);
        logic [31:0] v = '0;
        for (int i = 0; i < nb; i++) begin
            int k = (a + i) & 32'h3FFFFF;
            v[8*i +: 8] = mem.exists(k) ? mem[k] : seed_b(k);
        end
        return v;
    endfunction

    function automatic logic [31:0] ref_px(int a, int nb);
        logic [31:0] v = '0;
        for (int i = 0; i < nb; i++) begin
            int k = (a + i) & 32'h3FFFFF;
            v[8*i +: 8] = refm.exists(k) ? refm[k] : seed_b(k);
        end
        return v;
    endfunction

    function automatic logic [31:0] bmix(logic [3:0] c, logic [31:0] s, logic [31:0] d);
        case (c)
            4'h0: return 32'h0;
            4'h1: return s & d;
            4'h2: return s & ~d;
            4'h3: return s;
            4'h4: return ~s & d;
            4'h5: return d;
            4'h6: return s ^ d;
            4'h7: return s | d;
            4'h8: return ~(s | d);
            4'h9: return ~(s ^ d);
            4'hA: return ~d;
            4'hB: return s | ~d;
            4'hC: return ~s;
            4'hD: return ~s | d;
            4'hE: return ~(s & d);
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // reference model: R3 R4 R5 R6 R7 R8 R11 R12
    task automatic build_exp();
        int nb = dep + 1;
        bit us = !(mx == 4'h0 || mx == 4'h5 || mx == 4'hA || mx == 4'hF);
        bit ud = !(mx == 4'h0 || mx == 4'h3 || mx == 4'hC || mx == 4'hF);
        logic [31:0] msk = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 1);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                int idx = y * w + x;
                int oy = yn ? -y : y;
                int ox = xn ? -x : x;
                int sa = (ss + oy * sp + ox * nb) & 32'h3FFFFF;
                int da = (ds + oy * dp + ox * nb) & 32'h3FFFFF;
                logic [31:0] s, d, r;
                txn_t t;
                if (drw == 1 && idx == 0) continue;
                if (drw == 2 && idx == w * h - 1) continue;
                s = fg;
                d = 32'h0;
                if (fs && us) begin
                    s = ref_px(sa, nb);
                    t = '{0, sa, nb, 32'h0};
                    exp_q.push_back(t);
                end
                if (ud) begin
                    d = ref_px(da, nb);
                    t = '{0, da, nb, 32'h0};
                    exp_q.push_back(t);
                end
                r = bmix(mx, s, d) & msk;
                t = '{1, da, nb, r};
                exp_q.push_back(t);
                for (int i = 0; i < nb; i++) refm[(da + i) & 32'h3FFFFF] = r[8*i +: 8];
            end
        end
    endtask

    // memory responder and per-clock comparison
    bit          prev_stall = 0;
    logic [21:0] prev_addr;
    logic        prev_we;
    always @(negedge clk) begin
        txn_t t;
        mem_ready = stall ? (($urandom % 3) != 0) : 1'b1;
        mem_rdata = mem_px(int'(mem_addr), int'(mem_size) + 1);
        if (!rst) begin
            if (prev_stall)
                check(mem_valid && mem_addr == prev_addr && mem_we == prev_we,
                      "R9", "stalled request changed", {9'b0, mem_we, mem_addr}, {9'b0, prev_we, prev_addr});
            if (mem_valid && mem_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected request", {9'b0, mem_we, mem_addr}, 32'h0);
                end else begin
                    t = exp_q.pop_front();
                    check(mem_we == t.we && int'(mem_addr) == t.addr && int'(mem_size) == t.nb - 1,
                          "R4", "request we/size/addr", {7'b0, mem_we, mem_size, mem_addr},
                          {7'b0, t.we, 2'(t.nb - 1), 22'(t.addr)});
                    if (t.we) begin
                        check(mem_wdata == t.data, "R6", "write data", mem_wdata, t.data);
                        for (int i = 0; i < t.nb; i++)
                            mem[(int'(mem_addr) + i) & 32'h3FFFFF] = mem_wdata[8*i +: 8];
                    end
                end
            end
            prev_stall = mem_valid && !mem_ready;
            prev_addr  = mem_addr;
            prev_we    = mem_we;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cfg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(bit go);
        return {12'h0, mx, 3'b0, fs, 2'b0, 2'(dep), 2'b0, 2'(drw), 1'b0, yn, xn, go};
    endfunction

    task automatic program_regs();
        // R3: junk in the unused size bits must be ignored
        cfg_write(3'd1, {4'hA, 12'(h - 1), 4'h5, 12'(w - 1)});
        cfg_write(3'd2, {4'h0, 12'(dp), 4'h0, 12'(sp)});
        cfg_write(3'd3, 32'(ss));
        cfg_write(3'd4, 32'(ds));
        cfg_write(3'd5, fg);
        cfg_write(3'd0, ctrl_word(0));
    endtask

    task automatic run_op(bit prog, string tag);
        int n = 0;
        if (prog) program_regs();
        build_exp();
        cfg_write(3'd0, ctrl_word(1));
        check(busy == 1'b1, "R2", {tag, " busy after start"}, 32'(busy), 32'h1);
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(busy == 1'b0, "R2", {tag, " busy falls at end"}, 32'(busy), 32'h0);
        check(exp_q.size() == 0, "R3", {tag, " all requests issued"}, 32'(exp_q.size()), 32'h0);
        exp_q.delete();
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", 32'(busy), 32'h0);
        check(mem_valid == 1'b0, "R1", "valid in reset", 32'(mem_valid), 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(busy == 1'b0 && mem_valid == 1'b0, "R1", "idle after reset",
              {30'b0, busy, mem_valid}, 32'h0);

        // R4 R7 forward copy, 8bpp
        w = 4; h = 3; dep = 0; xn = 0; yn = 0; drw = 0; fs = 1; mx = 4'h3;
        ss = 32'h100; ds = 32'h2000; sp = 16; dp = 32; fg = 32'h0;
        run_op(1, "copy8");

        // R5 reversed both axes, 16bpp xor, with back-pressure (R9)
        stall = 1;
        w = 3; h = 2; dep = 1; xn = 1; yn = 1; mx = 4'h6;
        ss = 32'h3000; ds = 32'h4000; sp = 64; dp = 40;
        run_op(1, "rev16");

        // R7 R12 R11 constant colour, 24bpp, skip last
        w = 2; h = 2; dep = 2; xn = 0; yn = 1; drw = 2; fs = 0; mx = 4'hB;
        fg = 32'hAABB_CCDD; ds = 32'h5000; dp = 100;
        run_op(1, "col24");

        // R4 R11 wrap below zero, 32bpp, all-ones mix, skip first
        stall = 0;
        w = 3; h = 1; dep = 3; xn = 1; yn = 0; drw = 1; mx = 4'hF; ds = 0;
        run_op(1, "wrap32");

        // R11 single pixel suppressed both ways
        w = 1; h = 1; dep = 0; xn = 0; drw = 1; mx = 4'h6; fs = 1; ss = 32'h600; ds = 32'h700;
        run_op(1, "one_first");
        drw = 2;
        run_op(1, "one_last");

        // R6 R8 every mix code
        drw = 0; w = 2; h = 1; fs = 1; fg = 32'h0;
        for (int c = 0; c < 16; c++) begin
            mx = 4'(c);
            ss = 32'h8000 + c * 16; ds = 32'h9000 + c * 16;
            run_op(1, "mix");
        end

        // R10 writes and start while busy are ignored
        stall = 1;
        w = 4; h = 2; dep = 1; xn = 0; yn = 0; drw = 0; fs = 0; mx = 4'h7;
        fg = 32'h0000_1234; ds = 32'hA000; dp = 64;
        fork
            run_op(1, "busy_write");
            begin
                wait (busy);
                repeat (3) @(negedge clk);
                cfg_write(3'd5, 32'hFFFF_0F0F);
                cfg_write(3'd0, 32'h000C_1335);
                cfg_write(3'd4, 32'h0001_0000);
            end
        join
        // R10 registers kept the earlier values: start again without reprogramming
        stall = 0;
        run_op(0, "busy_keep");

        repeat (4) @(negedge clk);
        check(mem_valid == 1'b0, "R1", "quiet when idle", 32'(mem_valid), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule